// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block sits on a simple register write bus and shields a small group of control registers against stray writes. A single protect flag decides whether writes to that group land or are dropped. Software cannot set the flag directly: it flips only after an exact run of four writes spread over two key addresses, each with a fixed data pattern. Any other write in between aborts the run.

The guarded registers live inside the block as a small array. A combinational read port returns any of them, or the protect flag at a status address. While protection is on, each dropped write raises a one-cycle violation pulse. Other logic can count these pulses or raise an interrupt from them.

Address map with default parameters: guarded registers at 0x00 to 0x03, first key address 0x10, second key address 0x11, status at 0x12. The protect flag is bit 0 of the status word, and the other status bits read 0.

Top module: `wprot_top`

## Requirements
- R1: After reset the protect flag is 0, the violation output is 0, and every guarded register reads 0x00.
- R2: With protection off, a write to a guarded address (0x00 to 0x03) stores its data. The new value appears on rd_data in the cycle that follows the write's clock edge.
- R3: The unlock run is four writes in this order: 0x5A to 0x10, 0xA5 to 0x11, 0xA5 to 0x10, 0x5A to 0x11. When the fourth write is taken at clock edge E, the protect flag inverts at edge E+1.
- R4: Repeating the run inverts the flag again, so successive runs alternate it between on and off.
- R5: Any write that breaks the order sends the run back to its start, and a full new run is then needed. This covers a wrong data value, the wrong key address, or any other address, including a guarded register or the status address.
- R6: With protection on, a write to a guarded address leaves the register unchanged. The violation output is then 1 for exactly the cycle after that write's edge.
- R7: Reading address 0x12 returns the protect flag in bit 0 and zeros in the other bits. A write to 0x12 never changes the flag.
- R8: Cycles with no write neither advance nor cancel the run, and read-port activity has no effect on it.
- R9: A guarded write made in the cycle between the fourth key write and the flag change is judged by the old flag value.
- R10: Writes to either key address never change a guarded register and never raise the violation output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| prot_on | output | 1 | Protect flag, 1 means guarded writes are blocked |
| viol | output | 1 | One-cycle pulse per dropped guarded write |

## Verification
Two functions can meet in one cycle: the flag update that follows a completed key run, and a guarded write made in that same cycle. The bench provokes this by issuing the guarded write straight after the fourth key write, once while the flag is off and once while it is on. It expects the data to be stored in the first case and dropped with a violation pulse in the second. A behavioural model of the run progress, the flag and the register contents is compared against prot_on, viol and rd_data on every cycle. Directed checks cover aborted runs, idle gaps, read traffic and status writes.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_K1A  = 3'd1,
    SEQ_K1B  = 3'd2,
    SEQ_K2A  = 3'd3,
    SEQ_TOG  = 3'd4
  } seq_e;

  localparam logic [7:0] KEY_PAT_A = 8'h5A;
  localparam logic [7:0] KEY_PAT_B = 8'hA5;

endpackage

// File: rtl/wp_key_seq.sv
module wp_key_seq
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              toggle_req
);

  localparam logic [DATA_W-1:0] PAT_A = DATA_W'(KEY_PAT_A);
  localparam logic [DATA_W-1:0] PAT_B = DATA_W'(KEY_PAT_B);

  seq_e state_q, state_d;
  logic k1_a, k1_b, k2_a, k2_b;

  always_comb begin
    k1_a = (wr_addr == KEY1_ADDR) && (wr_data == PAT_A);
    k1_b = (wr_addr == KEY1_ADDR) && (wr_data == PAT_B);
    k2_a = (wr_addr == KEY2_ADDR) && (wr_data == PAT_A);
    k2_b = (wr_addr == KEY2_ADDR) && (wr_data == PAT_B);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE, SEQ_TOG: begin
        if (wr_en && k1_a) state_d = SEQ_K1A;
        else               state_d = SEQ_IDLE;
      end
      SEQ_K1A: if (wr_en) state_d = k2_b ? SEQ_K1B : SEQ_IDLE;
      SEQ_K1B: if (wr_en) state_d = k1_b ? SEQ_K2A : SEQ_IDLE;
      SEQ_K2A: if (wr_en) state_d = k2_a ? SEQ_TOG : SEQ_IDLE;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign toggle_req = (state_q == SEQ_TOG);

endmodule

// File: rtl/wp_prot_gate.sv
module wp_prot_gate #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              toggle_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              prot_on,
  output logic              viol,
  output logic              bank_we
);

  logic in_bank;
  logic prot_q, prot_d;
  logic viol_q, viol_d;

  always_comb begin
    in_bank = (wr_addr < ADDR_W'(NREG));
    bank_we = wr_en && in_bank && !prot_q;
    viol_d  = wr_en && in_bank && prot_q;
    prot_d  = !prot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
    end else if (toggle_req) begin
      prot_q <= prot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign prot_on = prot_q;
  assign viol    = viol_q;

endmodule

// File: rtl/wp_reg_bank.sv
module wp_reg_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NREG   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bank_we,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] reg_flat
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              sel;
    logic [DATA_W-1:0] q;

    assign sel = bank_we && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (sel) q <= wr_data;
    end

    assign reg_flat[i*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/wprot_top.sv
module wprot_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              prot_on,
  output logic              viol
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic                   toggle_req;
  logic                   bank_we;
  logic [NREG*DATA_W-1:0] reg_flat;
  logic [IDX_W-1:0]       rd_idx;

  wp_key_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .toggle_req(toggle_req)
  );

  wp_prot_gate #(.ADDR_W(ADDR_W), .NREG(NREG)) u_gate (
    .clk(clk), .rst_n(rst_n), .toggle_req(toggle_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .prot_on(prot_on), .viol(viol), .bank_we(bank_we)
  );

  wp_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .wr_addr(wr_addr),
    .wr_data(wr_data), .reg_flat(reg_flat)
  );

  assign rd_idx = rd_addr[IDX_W-1:0];

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NREG))
      rd_data = reg_flat[rd_idx*DATA_W +: DATA_W];
    else if (rd_addr == STAT_ADDR)
      rd_data = {{(DATA_W-1){1'b0}}, prot_on};
  end

endmodule

// File: rtl/wprot_chk.sv
module wprot_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [DATA_W-1:0]      rd_data,
  input logic                   prot_on,
  input logic                   viol,
  input logic [NREG*DATA_W-1:0] reg_flat
);

  p_viol_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(wr_en && (wr_addr < ADDR_W'(NREG)) && prot_on));

  p_drop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < ADDR_W'(NREG)) && prot_on) |=> $stable(reg_flat));

  p_toggle_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on != $past(prot_on)) |->
      $past(wr_en && (wr_addr == KEY2_ADDR) && (wr_data == DATA_W'(8'h5A)), 2));

  p_key_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_addr == KEY1_ADDR) || (wr_addr == KEY2_ADDR)))
      |=> (!viol && $stable(reg_flat)));

  p_stat_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == STAT_ADDR) |-> (rd_data == {{(DATA_W-1){1'b0}}, prot_on}));

endmodule

bind wprot_top wprot_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
  .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .prot_on(prot_on), .viol(viol), .reg_flat(reg_flat)
);

// File: tb/wprot_top_bench.sv
`timescale 1ns/1ps
module wprot_top_bench;

  localparam logic [7:0] K1 = 8'h10;
  localparam logic [7:0] K2 = 8'h11;
  localparam logic [7:0] ST = 8'h12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       prot_on;
  logic       viol;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wprot_top u_wprot_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .prot_on(prot_on), .viol(viol)
  );

  // Behavioural reference: progress counter 0..3, pending flip, flag, registers
  int         m_prog = 0;
  bit         m_tog = 1'b0;
  bit         m_prot = 1'b0;
  bit         m_viol = 1'b0;
  bit         m_old = 1'b0;
  int         m_p = 0;
  logic [7:0] m_regs [4] = '{default: 8'h00};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prog = 0; m_tog = 0; m_prot = 0; m_viol = 0;
      for (int i = 0; i < 4; i++) m_regs[i] = 8'h00;
    end else begin
      m_old  = m_prot;
      m_viol = wr_en && (wr_addr < 8'd4) && m_old;
      if (wr_en && (wr_addr < 8'd4) && !m_old) m_regs[wr_addr[1:0]] = wr_data;
      m_p = m_tog ? 0 : m_prog;
      if (m_tog) m_prot = !m_prot;
      m_tog = 1'b0;
      if (wr_en) begin
        if (m_p == 0 && wr_addr == K1 && wr_data == 8'h5A) m_prog = 1;
        else if (m_p == 1 && wr_addr == K2 && wr_data == 8'hA5) m_prog = 2;
        else if (m_p == 2 && wr_addr == K1 && wr_data == 8'hA5) m_prog = 3;
        else if (m_p == 3 && wr_addr == K2 && wr_data == 8'h5A) begin
          m_prog = 0; m_tog = 1'b1;
        end else m_prog = 0;
      end else m_prog = m_p;
    end
  end

  function automatic logic [7:0] m_rd(input logic [7:0] a);
    if (a < 8'd4) return m_regs[a[1:0]];
    if (a == ST)  return {7'd0, m_prot};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2 read data, R3 flag, R6 pulse)
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R3 model prot_on", {7'd0, prot_on}, {7'd0, m_prot});
      chk("R6 model viol", {7'd0, viol}, {7'd0, m_viol});
      chk("R2 model rd_data", rd_data, m_rd(rd_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic run_keys();
    wr(K1, 8'h5A); wr(K2, 8'hA5); wr(K1, 8'hA5); wr(K2, 8'h5A);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 prot_on", {7'd0, prot_on}, 8'h00);
    chk("R1 viol", {7'd0, viol}, 8'h00);
    rd(8'h00, 8'h00, "R1 reg0");
    rd(8'h03, 8'h00, "R1 reg3");

    // R2 write while unprotected
    wr(8'h01, 8'h33);
    rd(8'h01, 8'h33, "R2 reg1 stored");
    wr(8'h03, 8'hC4);
    rd(8'h03, 8'hC4, "R2 reg3 stored");

    // R3 unlock run, flag flips one edge after the fourth write
    run_keys();
    chk("R3 flag before flip", {7'd0, prot_on}, 8'h00);
    chk("R10 no viol from key writes", {7'd0, viol}, 8'h00);
    idle(1);
    chk("R3 flag on", {7'd0, prot_on}, 8'h01);
    rd(ST, 8'h01, "R7 status reads flag");

    // R6 dropped write and single pulse
    wr(8'h01, 8'h77);
    chk("R6 viol pulse", {7'd0, viol}, 8'h01);
    rd(8'h01, 8'h33, "R6 reg1 unchanged");
    idle(1);
    chk("R6 pulse ends", {7'd0, viol}, 8'h00);

    // R5 aborted runs
    wr(K1, 8'h5A); wr(K2, 8'hA5); wr(8'h20, 8'h00); wr(K1, 8'hA5); wr(K2, 8'h5A);
    idle(2);
    chk("R5 other address aborts", {7'd0, prot_on}, 8'h01);
    wr(K1, 8'h5A); wr(K2, 8'hA5); wr(K1, 8'hA5); wr(K2, 8'hA6);
    idle(2);
    chk("R5 wrong data aborts", {7'd0, prot_on}, 8'h01);
    wr(K2, 8'h5A); wr(K2, 8'hA5); wr(K1, 8'hA5); wr(K2, 8'h5A);
    idle(2);
    chk("R5 wrong key register aborts", {7'd0, prot_on}, 8'h01);
    wr(K1, 8'h5A); wr(8'h02, 8'h01); wr(K2, 8'hA5); wr(K1, 8'hA5); wr(K2, 8'h5A);
    idle(2);
    chk("R5 guarded write aborts", {7'd0, prot_on}, 8'h01);

    // R8 idle gaps and read traffic inside the run; R4 flips back off
    wr(K1, 8'h5A); idle(2); rd(8'h00, 8'h00, "R8 read mid run");
    wr(K2, 8'hA5); rd(ST, 8'h01, "R8 status mid run"); idle(3);
    wr(K1, 8'hA5); rd(8'h03, 8'hC4, "R8 read mid run 2");
    wr(K2, 8'h5A);
    idle(1);
    chk("R4 flag back off", {7'd0, prot_on}, 8'h00);
    chk("R8 run survived gaps", {7'd0, prot_on}, 8'h00);

    // R7 status write has no effect
    wr(ST, 8'hFF);
    idle(1);
    rd(ST, 8'h00, "R7 status write ignored");

    // R9 guarded write in the flip cycle, flag off then on
    run_keys();
    wr(8'h02, 8'h99);
    chk("R9 no viol on old flag off", {7'd0, viol}, 8'h00);
    rd(8'h02, 8'h99, "R9 stored under old flag");
    chk("R9 flag now on", {7'd0, prot_on}, 8'h01);
    run_keys();
    wr(8'h02, 8'h11);
    chk("R9 viol on old flag on", {7'd0, viol}, 8'h01);
    rd(8'h02, 8'h99, "R9 dropped under old flag");
    chk("R9 flag now off", {7'd0, prot_on}, 8'h00);

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule